// File: doc/BRIEF.md
# Windowed Frame-Buffer Address Counter

This block produces the X (byte column) and Y (line) address for a frame-buffer RAM whose writes are confined to a rectangle. The host programs the X and Y window limits, presets the two counters, and chooses a direction for each axis and which axis moves on every write. After that, each write-advance strobe moves the counters one step through the rectangle, so a stream of pixel bytes lands in the window without further address traffic.

The axis chosen as primary steps on every advance. When it sits on its window end, it returns to its window start and the other axis takes one step in its own direction. When that axis also sits on its end, it returns to its own start, so the whole rectangle wraps. The window end is read in the direction of travel: a decrementing axis is expected to have a start above its end.

Top module: `win_addr_gen`

## Requirements
- R1: After the asynchronous reset, x_o is 0x01 and y_o is 0x127. The X window is 0x01 to 0x13, the Y window is 0x127 to 0x000, both axes count up, and X is the primary axis.
- R2: Direction code dir_i[1] = 1 makes Y count up and 0 makes it count down. dir_i[0] = 1 makes X count up and 0 makes it count down. Code 2'b11 is the reset value.
- R3: With y_first = 0, X is the primary axis and steps on every advance. With y_first = 1, Y is the primary axis.
- R4: On an advance where the primary axis is not on its window end, the primary counter moves by one in its direction and the secondary counter holds.
- R5: On an advance where the primary axis is on its window end, the primary counter reloads its window start and the secondary counter moves by one in its direction.
- R6: When both axes are on their window ends, an advance reloads both window starts.
- R7: A counter load sets that counter to the given value on the next edge. In the same cycle it takes precedence over an advance for that axis only.
- R8: soft_rst_i returns the counters, the window limits and the mode to their reset values on the next edge. It takes precedence over every load and advance.
- R9: With no advance, load or soft reset, both counters hold.
- R10: A window or mode load leaves both counters unchanged and governs the advances that follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Synchronous return to reset values |
| xwin_ld_i | input | 1 | Load the X window start and end |
| xs_i | input | XW | X window start |
| xe_i | input | XW | X window end |
| ywin_ld_i | input | 1 | Load the Y window start and end |
| ys_i | input | YW | Y window start |
| ye_i | input | YW | Y window end |
| xcnt_ld_i | input | 1 | Load the X counter |
| xcnt_i | input | XW | X counter value |
| ycnt_ld_i | input | 1 | Load the Y counter |
| ycnt_i | input | YW | Y counter value |
| mode_ld_i | input | 1 | Load the direction and primary-axis mode |
| dir_i | input | 2 | [1] Y up, [0] X up |
| y_first_i | input | 1 | 1 selects Y as the primary axis |
| adv_i | input | 1 | Write-advance strobe |
| x_o | output | XW | Current X address |
| y_o | output | YW | Current Y address |

## Verification
The hardest case to reach is the double wrap: both axes sitting on their ends at once, in every mix of direction and primary axis. With the reset window this would take thousands of advances. The stimulus therefore loads small three-position windows, presets the counters next to the ends, and then walks across the corner with a few advances, once for each mode. A separate run from reset covers the full default X span, to confirm the reset limits.

// File: rtl/wag_pkg.sv
package wag_pkg;
  typedef struct packed {
    logic y_up;
    logic x_up;
    logic y_first;
  } mode_t;

  localparam mode_t MODE_RST = '{y_up: 1'b1, x_up: 1'b1, y_first: 1'b0};
endpackage

// File: rtl/wag_cfg.sv
module wag_cfg
  import wag_pkg::*;
#(
  parameter int XW = 5,
  parameter int YW = 9,
  parameter logic [XW-1:0] XS_RST = 'h01,
  parameter logic [XW-1:0] XE_RST = 'h13,
  parameter logic [YW-1:0] YS_RST = 'h127,
  parameter logic [YW-1:0] YE_RST = 'h000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          soft_rst_i,
  input  logic          xwin_ld_i,
  input  logic [XW-1:0] xs_i,
  input  logic [XW-1:0] xe_i,
  input  logic          ywin_ld_i,
  input  logic [YW-1:0] ys_i,
  input  logic [YW-1:0] ye_i,
  input  logic          mode_ld_i,
  input  logic [1:0]    dir_i,
  input  logic          y_first_i,
  output logic [XW-1:0] xs_o,
  output logic [XW-1:0] xe_o,
  output logic [YW-1:0] ys_o,
  output logic [YW-1:0] ye_o,
  output mode_t         mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xs_o <= XS_RST; xe_o <= XE_RST;
      ys_o <= YS_RST; ye_o <= YE_RST;
      mode_o <= MODE_RST;
    end else if (soft_rst_i) begin
      xs_o <= XS_RST; xe_o <= XE_RST;
      ys_o <= YS_RST; ye_o <= YE_RST;
      mode_o <= MODE_RST;
    end else begin
      if (xwin_ld_i) begin xs_o <= xs_i; xe_o <= xe_i; end
      if (ywin_ld_i) begin ys_o <= ys_i; ye_o <= ye_i; end
      if (mode_ld_i) mode_o <= '{y_up: dir_i[1], x_up: dir_i[0], y_first: y_first_i};
    end
  end

  // R8
  cfg_soft_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (xs_o == XS_RST && xe_o == XE_RST && ys_o == YS_RST &&
                    ye_o == YE_RST && mode_o == MODE_RST));

  // R10
  cfg_mode_ld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_ld_i && !soft_rst_i) |=> (mode_o.y_first == $past(y_first_i)));
endmodule

// File: rtl/wag_axis.sv
module wag_axis #(
  parameter int W = 5,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         soft_rst_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         step_i,
  input  logic         up_i,
  input  logic [W-1:0] start_i,
  input  logic [W-1:0] end_i,
  output logic [W-1:0] cnt_o,
  output logic         at_end_o
);
  logic [W-1:0] nxt;

  assign at_end_o = (cnt_o == end_i);

  always_comb begin
    if (at_end_o)  nxt = start_i;
    else if (up_i) nxt = cnt_o + 1'b1;
    else           nxt = cnt_o - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_o <= RST;
    else if (soft_rst_i) cnt_o <= RST;
    else if (ld_i)       cnt_o <= ld_val_i;
    else if (step_i)     cnt_o <= nxt;
  end

  // R5
  axis_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && at_end_o && !ld_i && !soft_rst_i) |=> (cnt_o == $past(start_i)));

  // R7
  axis_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && !soft_rst_i) |=> (cnt_o == $past(ld_val_i)));

  // R9
  axis_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !ld_i && !soft_rst_i) |=> $stable(cnt_o));
endmodule

// File: rtl/win_addr_gen.sv
module win_addr_gen
  import wag_pkg::*;
#(
  parameter int XW = 5,
  parameter int YW = 9,
  parameter logic [XW-1:0] XS_RST = 'h01,
  parameter logic [XW-1:0] XE_RST = 'h13,
  parameter logic [YW-1:0] YS_RST = 'h127,
  parameter logic [YW-1:0] YE_RST = 'h000,
  parameter logic [XW-1:0] XC_RST = 'h01,
  parameter logic [YW-1:0] YC_RST = 'h127
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          soft_rst_i,
  input  logic          xwin_ld_i,
  input  logic [XW-1:0] xs_i,
  input  logic [XW-1:0] xe_i,
  input  logic          ywin_ld_i,
  input  logic [YW-1:0] ys_i,
  input  logic [YW-1:0] ye_i,
  input  logic          xcnt_ld_i,
  input  logic [XW-1:0] xcnt_i,
  input  logic          ycnt_ld_i,
  input  logic [YW-1:0] ycnt_i,
  input  logic          mode_ld_i,
  input  logic [1:0]    dir_i,
  input  logic          y_first_i,
  input  logic          adv_i,
  output logic [XW-1:0] x_o,
  output logic [YW-1:0] y_o
);
  logic [XW-1:0] xs, xe;
  logic [YW-1:0] ys, ye;
  mode_t         mode;
  logic          x_end, y_end, x_step, y_step;

  wag_cfg #(
    .XW(XW), .YW(YW), .XS_RST(XS_RST), .XE_RST(XE_RST), .YS_RST(YS_RST), .YE_RST(YE_RST)
  ) u_cfg (
    .clk_i, .rst_ni, .soft_rst_i,
    .xwin_ld_i, .xs_i, .xe_i, .ywin_ld_i, .ys_i, .ye_i,
    .mode_ld_i, .dir_i, .y_first_i,
    .xs_o(xs), .xe_o(xe), .ys_o(ys), .ye_o(ye), .mode_o(mode)
  );

  // primary steps on every advance, secondary only when primary wraps
  assign x_step = adv_i & (mode.y_first ? y_end : 1'b1);
  assign y_step = adv_i & (mode.y_first ? 1'b1 : x_end);

  wag_axis #(.W(XW), .RST(XC_RST)) u_x (
    .clk_i, .rst_ni, .soft_rst_i,
    .ld_i(xcnt_ld_i), .ld_val_i(xcnt_i), .step_i(x_step), .up_i(mode.x_up),
    .start_i(xs), .end_i(xe), .cnt_o(x_o), .at_end_o(x_end)
  );

  wag_axis #(.W(YW), .RST(YC_RST)) u_y (
    .clk_i, .rst_ni, .soft_rst_i,
    .ld_i(ycnt_ld_i), .ld_val_i(ycnt_i), .step_i(y_step), .up_i(mode.y_up),
    .start_i(ys), .end_i(ye), .cnt_o(y_o), .at_end_o(y_end)
  );

  // R4
  sec_hold_x_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !soft_rst_i && !ycnt_ld_i && !mode.y_first && x_o != xe) |=> $stable(y_o));

  // R4
  sec_hold_y_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !soft_rst_i && !xcnt_ld_i && mode.y_first && y_o != ye) |=> $stable(x_o));

  // R8
  soft_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (x_o == XC_RST && y_o == YC_RST));

  // R10
  win_ld_no_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((xwin_ld_i || ywin_ld_i || mode_ld_i) && !adv_i && !soft_rst_i && !xcnt_ld_i && !ycnt_ld_i)
      |=> ($stable(x_o) && $stable(y_o)));
endmodule

// File: tb/sim_win_addr_gen.sv
module sim_win_addr_gen;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       soft_rst, xwin_ld, ywin_ld, xcnt_ld, ycnt_ld, mode_ld, y_first, adv;
  logic [4:0] xs, xe, xcnt;
  logic [8:0] ys, ye, ycnt;
  logic [1:0] dir;
  logic [4:0] x;
  logic [8:0] y;
  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  win_addr_gen u0 (
    .clk_i(clk), .rst_ni(rst_ni), .soft_rst_i(soft_rst),
    .xwin_ld_i(xwin_ld), .xs_i(xs), .xe_i(xe),
    .ywin_ld_i(ywin_ld), .ys_i(ys), .ye_i(ye),
    .xcnt_ld_i(xcnt_ld), .xcnt_i(xcnt), .ycnt_ld_i(ycnt_ld), .ycnt_i(ycnt),
    .mode_ld_i(mode_ld), .dir_i(dir), .y_first_i(y_first), .adv_i(adv),
    .x_o(x), .y_o(y)
  );

  localparam int OP_NOP = 0, OP_ADV = 1, OP_XWIN = 2, OP_YWIN = 3,
                 OP_XCNT = 4, OP_YCNT = 5, OP_MODE = 6, OP_SOFT = 7;
  // {op[38:36], a[35:27], b[26:18], exp_x[17:13], exp_y[12:4], req[3:0]}
  // MODE operand a: [1:0] direction code, [2] y_first
  localparam int NV = 38;
  localparam logic [38:0] VEC [NV] = '{
    {3'd2, 9'd2, 9'd4, 5'h01, 9'h127, 4'd10},  // R10 X window 2..4
    {3'd3, 9'd5, 9'd7, 5'h01, 9'h127, 4'd10},  // R10 Y window 5..7
    {3'd4, 9'd2, 9'd0, 5'h02, 9'h127, 4'd7},   // R7
    {3'd5, 9'd5, 9'd0, 5'h02, 9'h005, 4'd7},   // R7
    {3'd6, 9'd3, 9'd0, 5'h02, 9'h005, 4'd10},  // R10 up/up, X first
    {3'd1, 9'd0, 9'd0, 5'h03, 9'h005, 4'd4},   // R4
    {3'd1, 9'd0, 9'd0, 5'h04, 9'h005, 4'd4},
    {3'd1, 9'd0, 9'd0, 5'h02, 9'h006, 4'd5},   // R5
    {3'd1, 9'd0, 9'd0, 5'h03, 9'h006, 4'd4},
    {3'd1, 9'd0, 9'd0, 5'h04, 9'h006, 4'd4},
    {3'd1, 9'd0, 9'd0, 5'h02, 9'h007, 4'd5},
    {3'd1, 9'd0, 9'd0, 5'h03, 9'h007, 4'd4},
    {3'd1, 9'd0, 9'd0, 5'h04, 9'h007, 4'd4},
    {3'd1, 9'd0, 9'd0, 5'h02, 9'h005, 4'd6},   // R6 double wrap
    {3'd0, 9'd0, 9'd0, 5'h02, 9'h005, 4'd9},   // R9
    {3'd6, 9'd0, 9'd0, 5'h02, 9'h005, 4'd10},  // down/down, X first
    {3'd2, 9'd4, 9'd2, 5'h02, 9'h005, 4'd10},
    {3'd3, 9'd7, 9'd5, 5'h02, 9'h005, 4'd10},
    {3'd4, 9'd4, 9'd0, 5'h04, 9'h005, 4'd7},
    {3'd5, 9'd7, 9'd0, 5'h04, 9'h007, 4'd7},
    {3'd1, 9'd0, 9'd0, 5'h03, 9'h007, 4'd2},   // R2 X down
    {3'd1, 9'd0, 9'd0, 5'h02, 9'h007, 4'd2},
    {3'd1, 9'd0, 9'd0, 5'h04, 9'h006, 4'd2},   // R2 Y down on wrap
    {3'd6, 9'd5, 9'd0, 5'h04, 9'h006, 4'd10},  // Y down X up, Y first
    {3'd2, 9'd2, 9'd4, 5'h04, 9'h006, 4'd10},
    {3'd4, 9'd2, 9'd0, 5'h02, 9'h006, 4'd7},
    {3'd5, 9'd7, 9'd0, 5'h02, 9'h007, 4'd7},
    {3'd1, 9'd0, 9'd0, 5'h02, 9'h006, 4'd3},   // R3 Y primary
    {3'd1, 9'd0, 9'd0, 5'h02, 9'h005, 4'd3},
    {3'd1, 9'd0, 9'd0, 5'h03, 9'h007, 4'd5},
    {3'd6, 9'd6, 9'd0, 5'h03, 9'h007, 4'd10},  // Y up X down, Y first
    {3'd3, 9'd5, 9'd7, 5'h03, 9'h007, 4'd10},
    {3'd2, 9'd4, 9'd2, 5'h03, 9'h007, 4'd10},
    {3'd1, 9'd0, 9'd0, 5'h02, 9'h005, 4'd5},
    {3'd1, 9'd0, 9'd0, 5'h02, 9'h006, 4'd3},
    {3'd1, 9'd0, 9'd0, 5'h02, 9'h007, 4'd3},
    {3'd1, 9'd0, 9'd0, 5'h04, 9'h005, 4'd6},   // R6 double wrap, Y first
    {3'd7, 9'd0, 9'd0, 5'h01, 9'h127, 4'd8}    // R8
  };

  task automatic idle();
    soft_rst = 0; xwin_ld = 0; ywin_ld = 0; xcnt_ld = 0; ycnt_ld = 0;
    mode_ld = 0; adv = 0; xs = '0; xe = '0; ys = '0; ye = '0;
    xcnt = '0; ycnt = '0; dir = '0; y_first = 0;
  endtask

  task automatic check(input int req, input logic [4:0] ex, input logic [8:0] ey);
    n_run++;
    if (x !== ex || y !== ey) begin
      n_fail++;
      $display("FAIL R%0d: x=%h y=%h expected x=%h y=%h", req, x, y, ex, ey);
    end
  endtask

  // drive at a negedge, registers update at the posedge, sample at the next negedge
  task automatic do_op(input int op, input logic [8:0] a, input logic [8:0] b);
    case (op)
      OP_ADV:  adv = 1;
      OP_XWIN: begin xwin_ld = 1; xs = a[4:0]; xe = b[4:0]; end
      OP_YWIN: begin ywin_ld = 1; ys = a; ye = b; end
      OP_XCNT: begin xcnt_ld = 1; xcnt = a[4:0]; end
      OP_YCNT: begin ycnt_ld = 1; ycnt = a; end
      OP_MODE: begin mode_ld = 1; dir = a[1:0]; y_first = a[2]; end
      OP_SOFT: soft_rst = 1;
      default: ;
    endcase
    @(negedge clk);
    idle();
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    join_none
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    check(1, 5'h01, 9'h127);  // R1 reset values

    // R1 default X window 01..13 reached from reset with Y up
    for (int i = 0; i < 18; i++) do_op(OP_ADV, 0, 0);
    check(1, 5'h13, 9'h127);
    do_op(OP_ADV, 0, 0);
    check(1, 5'h01, 9'h128);  // R1 wrap to default start, Y up one
    do_op(OP_NOP, 0, 0);
    check(9, 5'h01, 9'h128);  // R9
    do_op(OP_SOFT, 0, 0);
    check(8, 5'h01, 9'h127);  // R8

    for (int i = 0; i < NV; i++) begin
      do_op(int'(VEC[i][38:36]), VEC[i][35:27], VEC[i][26:18]);
      check(int'(VEC[i][3:0]), VEC[i][17:13], VEC[i][12:4]);
    end

    // R7 X load wins over advance on X; Y holds since X was not at end
    xcnt_ld = 1; xcnt = 5'h05; adv = 1;
    @(negedge clk); idle();
    check(7, 5'h05, 9'h127);
    // R7 Y load with advance: X still steps
    ycnt_ld = 1; ycnt = 9'h009; adv = 1;
    @(negedge clk); idle();
    check(7, 5'h06, 9'h009);
    // R8 soft reset beats loads and advance
    soft_rst = 1; xcnt_ld = 1; xcnt = 5'h1f; ycnt_ld = 1; ycnt = 9'h0aa; adv = 1;
    @(negedge clk); idle();
    check(8, 5'h01, 9'h127);
    // R8 soft reset also restored window and mode: default X span again
    for (int i = 0; i < 19; i++) do_op(OP_ADV, 0, 0);
    check(8, 5'h01, 9'h128);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule